// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Generator

This block supervises a processor by driving an active-low reset line. Three sources can request reset. A synchronous power-on request starts a pulse. A manual-reset pin, active low, holds reset for as long as it stays low, after debouncing. A watchdog fires when its input stops toggling. Every request ends in the same stretched pulse. Reset releases only after a fixed number of millisecond ticks have passed with no request active.

The watchdog input and the manual-reset pin each pass through a multi-flop synchronizer first. Any edge of the watchdog input, rising or falling, restarts its count. Two control bits set how the watchdog runs: one enables it, the other chooses the short or the long timeout. The count is held at zero while reset is asserted, so the processor gets a full timeout window after each release. An expiry sets a sticky flag, and the flag stays set until it is acknowledged.

All timing is counted in ticks of the `tick_ms` strobe, which is one clock wide. All thresholds are parameters in ticks.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst` is high, `rst_n_out` is 0 and `wd_expired` is 0. After `rst` falls, `rst_n_out` stays 0 for RST_PULSE_MS further ticks and then rises.
- R2: A one-cycle `por_req` pulse asserts `rst_n_out` low before the next tick, and releases it RST_PULSE_MS ticks later.
- R3: `mr_n` held low for DEBOUNCE_MS consecutive ticks drives `rst_n_out` low. It stays low for as long as `mr_n` stays low, even beyond RST_PULSE_MS ticks.
- R4: After `mr_n` returns high, and once the debouncer accepts the high level after DEBOUNCE_MS ticks, `rst_n_out` stays low for RST_PULSE_MS more ticks.
- R5: A low excursion on `mr_n` that lasts fewer than DEBOUNCE_MS ticks has no effect on `rst_n_out`.
- R6: With `wd_en`=1 and `wd_long`=0, WD_SHORT_MS ticks with no edge on `wdi` cause an expiry. An expiry asserts `rst_n_out` low for RST_PULSE_MS ticks.
- R7: A rising edge and a falling edge on `wdi` each restart the watchdog count.
- R8: With `wd_long`=1, the timeout is WD_LONG_MS ticks instead of WD_SHORT_MS ticks.
- R9: With `wd_en`=0, the watchdog never expires, however long `wdi` stays still.
- R10: The watchdog count is held at zero while `rst_n_out` is low. After release, a fresh full timeout is needed before the next expiry.
- R11: An expiry sets `wd_expired`, which stays 1 until a `wd_ack` cycle clears it. If an expiry and an ack fall in the same cycle, the expiry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle strobe, once per millisecond |
| por_req | input | 1 | Synchronous power-on reset request |
| mr_n | input | 1 | Manual reset pin, active low, asynchronous |
| wdi | input | 1 | Watchdog service input, asynchronous |
| wd_en | input | 1 | Watchdog enable control bit |
| wd_long | input | 1 | Timeout select: 0 short, 1 long |
| wd_ack | input | 1 | Clears the expired flag |
| rst_n_out | output | 1 | Supervisor reset output, active low |
| wd_expired | output | 1 | Sticky watchdog-expired flag |

## Verification
Every result is due at a known tick, and each tick lands on a known clock edge. With inputs changed just after tick k:
- A `por_req` or `wd_ack` shows at the next edge, still at count k.
- A manual-reset assertion shows at tick k+DEBOUNCE_MS.
- A release shows RST_PULSE_MS ticks after the last request ended.
- A watchdog expiry shows, with the flag, at tick k+timeout, where k is the tick of the last edge on `wdi`.

The synchronizer and edge-detect latency of a few clocks always fits between two ticks. The bench drives inputs only just after a tick lands, and it queues each expected output transition together with its tick count. The monitor then checks every observed transition of `rst_n_out` and `wd_expired` against the head of that queue, so an early, late, missing or extra transition is a failure.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // width of a counter that must hold values 0..n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int STABLE_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic level
);
  localparam int W = sup_pkg::cnt_w(STABLE_TICKS);
  localparam logic [W-1:0] LAST = W'(STABLE_TICKS - 1);

  logic [W-1:0] run_cnt;

  // accept a new level only after it has differed on STABLE_TICKS ticks in a row
  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= 1'b1;
      run_cnt <= '0;
    end else if (din == level) begin
      run_cnt <= '0;
    end else if (tick) begin
      if (run_cnt == LAST) begin
        level   <= din;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int SHORT_TICKS = 200,
  parameter int LONG_TICKS  = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic wdi_s,
  input  logic en,
  input  logic long_sel,
  input  logic hold,
  output logic expire
);
  localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int W    = sup_pkg::cnt_w(MAXT);

  logic         wdi_d;
  logic         any_edge;
  logic         clear;
  logic [W-1:0] limit;
  logic [W-1:0] idle_cnt;

  assign any_edge = wdi_s ^ wdi_d;
  assign clear    = hold | ~en | any_edge;
  assign limit    = long_sel ? W'(LONG_TICKS - 1) : W'(SHORT_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wdi_d    <= 1'b0;
      idle_cnt <= '0;
      expire   <= 1'b0;
    end else begin
      wdi_d  <= wdi_s;
      expire <= 1'b0;
      if (clear) begin
        idle_cnt <= '0;
      end else if (tick) begin
        if (idle_cnt >= limit) begin
          idle_cnt <= '0;
          expire   <= 1'b1;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sup_pulse.sv
module sup_pulse #(
  parameter int PULSE_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  input  logic hold,
  output logic active
);
  localparam int W = sup_pkg::cnt_w(PULSE_TICKS);
  localparam logic [W-1:0] FULL = W'(PULSE_TICKS);

  logic [W-1:0] remain;
  logic [W-1:0] remain_nxt;

  always_comb begin
    if (start | hold)               remain_nxt = FULL;
    else if (tick && remain != '0)  remain_nxt = remain - 1'b1;
    else                            remain_nxt = remain;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= FULL;
      active <= 1'b1;
    end else begin
      remain <= remain_nxt;
      active <= (remain_nxt != '0);
    end
  end
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int SYNC_STAGES  = 2,
  parameter int RST_PULSE_MS = 200,
  parameter int DEBOUNCE_MS  = 20,
  parameter int WD_SHORT_MS  = 200,
  parameter int WD_LONG_MS   = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic por_req,
  input  logic mr_n,
  input  logic wdi,
  input  logic wd_en,
  input  logic wd_long,
  input  logic wd_ack,
  output logic rst_n_out,
  output logic wd_expired
);
  logic mr_s;
  logic wdi_s;
  logic mr_db;
  logic wd_expire;
  logic rst_active;
  logic expired_q;

  sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
    .clk(clk), .rst(rst), .d(mr_n), .q(mr_s)
  );

  sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wdi_sync (
    .clk(clk), .rst(rst), .d(wdi), .q(wdi_s)
  );

  sup_debounce #(.STABLE_TICKS(DEBOUNCE_MS)) u_mr_db (
    .clk(clk), .rst(rst), .tick(tick_ms), .din(mr_s), .level(mr_db)
  );

  sup_wdog #(.SHORT_TICKS(WD_SHORT_MS), .LONG_TICKS(WD_LONG_MS)) u_wdog (
    .clk(clk), .rst(rst), .tick(tick_ms), .wdi_s(wdi_s), .en(wd_en),
    .long_sel(wd_long), .hold(rst_active), .expire(wd_expire)
  );

  sup_pulse #(.PULSE_TICKS(RST_PULSE_MS)) u_pulse (
    .clk(clk), .rst(rst), .tick(tick_ms), .start(por_req | wd_expire),
    .hold(~mr_db), .active(rst_active)
  );

  // sticky flag: a new expiry outranks an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst)            expired_q <= 1'b0;
    else if (wd_expire) expired_q <= 1'b1;
    else if (wd_ack)    expired_q <= 1'b0;
  end

  assign rst_n_out  = ~rst_active;
  assign wd_expired = expired_q;
endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk (
  input logic clk,
  input logic rst,
  input logic wd_en,
  input logic wd_ack,
  input logic mr_db,
  input logic wd_expire,
  input logic rst_active,
  input logic rst_n_out,
  input logic wd_expired
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!rst_n_out && !wd_expired));

  // R3
  mr_asserts_chk: assert property (@(posedge clk) disable iff (rst)
    !mr_db |=> !rst_n_out);

  // R4
  release_after_mr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_out) |-> $past(mr_db));

  // R9
  wd_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    wd_expire |-> $past(wd_en));

  // R10
  wd_held_chk: assert property (@(posedge clk) disable iff (rst)
    wd_expire |-> !$past(rst_active));

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    wd_expire |=> wd_expired);

  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_expired) |-> $past(wd_ack));
endmodule

bind sup_reset_gen sup_reset_gen_chk u_chk (
  .clk(clk), .rst(rst), .wd_en(wd_en), .wd_ack(wd_ack), .mr_db(mr_db),
  .wd_expire(wd_expire), .rst_active(rst_active), .rst_n_out(rst_n_out),
  .wd_expired(wd_expired)
);

// File: tb/tb_sup_reset_gen.sv
module tb_sup_reset_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int P   = 6;
  localparam int D   = 4;
  localparam int S   = 10;
  localparam int LG  = 24;
  localparam int EV_RST_FALL = 0;
  localparam int EV_RST_RISE = 1;
  localparam int EV_FLG_RISE = 2;
  localparam int EV_FLG_FALL = 3;

  typedef struct {
    int    kind;
    int    tick;
    string tag;
  } ev_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_req = 1'b0;
  logic mr_n = 1'b1;
  logic wdi = 1'b0;
  logic wd_en = 1'b0;
  logic wd_long = 1'b0;
  logic wd_ack = 1'b0;
  logic tick_ms;
  logic rst_n_out;
  logic wd_expired;

  int div_cnt = 0;
  int tick_no = 0;
  int checks = 0;
  int fails = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  ev_t exp_q[$];

  sup_reset_gen #(
    .SYNC_STAGES(2), .RST_PULSE_MS(P), .DEBOUNCE_MS(D),
    .WD_SHORT_MS(S), .WD_LONG_MS(LG)
  ) dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .por_req(por_req), .mr_n(mr_n),
    .wdi(wdi), .wd_en(wd_en), .wd_long(wd_long), .wd_ack(wd_ack),
    .rst_n_out(rst_n_out), .wd_expired(wd_expired)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tick_ms = (div_cnt == DIV - 1);

  always @(posedge clk) begin
    div_cnt <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
    if (tick_ms) tick_no <= tick_no + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input int kind, input int tk, input string tag);
    ev_t e;
    e.kind = kind;
    e.tick = tk;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "unexpected", $sformatf("transition kind %0d at tick %0d", kind, tick_no),
            kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, e.tag, "transition kind", kind, e.kind);
      check(e.tick == tick_no, e.tag, "transition tick", tick_no, e.tick);
    end
  endtask

  // monitor: compares every output transition with the head of the queue
  bit prev_rn;
  bit prev_fl;
  always @(negedge clk) begin
    if (!mon_on) begin
      prev_rn = rst_n_out;
      prev_fl = wd_expired;
    end else begin
      if (rst_n_out !== prev_rn) observe(rst_n_out ? EV_RST_RISE : EV_RST_FALL);
      if (wd_expired !== prev_fl) observe(wd_expired ? EV_FLG_RISE : EV_FLG_FALL);
      prev_rn = rst_n_out;
      prev_fl = wd_expired;
    end
  end

  // wait until tick n has landed, then return at the following falling edge
  task automatic go(input int n);
    while (tick_no < n) @(negedge clk);
  endtask

  task automatic ack_pulse();
    wd_ack = 1'b1;
    @(negedge clk);
    wd_ack = 1'b0;
  endtask

  initial begin
    int t, k, k2, k3, m, k4, r, j, k5, j5, k6, k7, m7;
    repeat (5) @(negedge clk);
    check(rst_n_out == 1'b0, "R1", "rst_n_out in reset", rst_n_out, 0);
    check(wd_expired == 1'b0, "R1", "wd_expired in reset", wd_expired, 0);

    t = tick_no + 1;
    go(t);
    rst = 1'b0;
    mon_on = 1'b1;
    push(EV_RST_RISE, t + P, "R1");

    k = t + P + 2;
    push(EV_RST_FALL, k, "R2");
    push(EV_RST_RISE, k + P, "R2");
    go(k);
    por_req = 1'b1;
    @(negedge clk);
    por_req = 1'b0;

    // R5: glitch shorter than the debounce window
    k2 = k + P + 2;
    go(k2);
    mr_n = 1'b0;
    go(k2 + D - 2);
    mr_n = 1'b1;
    go(k2 + D + 6);
    check(rst_n_out == 1'b1, "R5", "rst_n_out after short glitch", rst_n_out, 1);

    // R3 / R4: long manual reset
    k3 = k2 + D + 8;
    push(EV_RST_FALL, k3 + D, "R3");
    go(k3);
    mr_n = 1'b0;
    go(k3 + 12);
    check(rst_n_out == 1'b0, "R3", "rst_n_out while mr_n low", rst_n_out, 0);
    m = k3 + 15;
    push(EV_RST_RISE, m + D + P, "R4");
    go(m);
    mr_n = 1'b1;

    // R6 / R11: short timeout expiry
    k4 = m + D + P + 2;
    push(EV_RST_FALL, k4 + S, "R6");
    push(EV_FLG_RISE, k4 + S, "R11");
    push(EV_RST_RISE, k4 + S + P, "R6");
    go(k4);
    wd_en = 1'b1;
    r = k4 + S + P;
    push(EV_FLG_FALL, r + 1, "R11");
    go(r + 1);
    ack_pulse();
    // R7: service on alternating edges, 6 ticks apart
    for (int i = 0; i < 6; i++) begin
      go(r + 3 + 6 * i);
      wdi = ~wdi;
    end
    j = r + 33;
    push(EV_RST_FALL, j + S, "R7");
    push(EV_FLG_RISE, j + S, "R11");
    push(EV_RST_RISE, j + S + P, "R7");

    // R8: long timeout
    k5 = j + S + P + 2;
    push(EV_FLG_FALL, k5, "R11");
    go(k5);
    wd_long = 1'b1;
    wdi = ~wdi;
    ack_pulse();
    for (int i = 1; i <= 3; i++) begin
      go(k5 + 20 * i);
      wdi = ~wdi;
    end
    j5 = k5 + 60;
    push(EV_RST_FALL, j5 + LG, "R8");
    push(EV_FLG_RISE, j5 + LG, "R11");
    push(EV_RST_RISE, j5 + LG + P, "R8");

    // R9: disabled watchdog
    k6 = j5 + LG + P + 1;
    push(EV_FLG_FALL, k6, "R11");
    go(k6);
    wd_en = 1'b0;
    ack_pulse();
    go(k6 + 40);
    check(rst_n_out == 1'b1, "R9", "rst_n_out with watchdog disabled", rst_n_out, 1);

    // R10: count held while reset is asserted
    k7 = k6 + 41;
    go(k7);
    wd_en = 1'b1;
    wd_long = 1'b0;
    wdi = ~wdi;
    push(EV_RST_FALL, k7 + 2 + D, "R10");
    go(k7 + 2);
    mr_n = 1'b0;
    m7 = k7 + 32;
    push(EV_RST_RISE, m7 + D + P, "R10");
    push(EV_RST_FALL, m7 + D + P + S, "R10");
    push(EV_FLG_RISE, m7 + D + P + S, "R10");
    push(EV_RST_RISE, m7 + D + P + S + P, "R10");
    go(m7);
    mr_n = 1'b1;
    go(m7 + D + P + S + P + 1);
    wd_en = 1'b0;
    go(m7 + D + P + S + P + 6);

    check(exp_q.size() == 0, "R10", "pending expected transitions", exp_q.size(), 0);
    check(rst_n_out == 1'b1, "R10", "rst_n_out at end", rst_n_out, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL all requirements: watchdog timeout, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule